// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block turns a 32-bit local bus address into a downstream bus address plus a cycle type, using three programmable windows. Software programs each window through a small write-only register port: a base register chooses which local addresses the window claims, and a map register chooses where those addresses land downstream and which kind of downstream cycle they become. A lookup presented on the request port is answered one clock later with a hit flag, the index of the winning window, the translated address, the cycle type and an address-low-enable flag.

Windows may overlap. The windows are checked in a fixed order, lowest index first, and the first enabled window that claims the address supplies the translation. Software can therefore enlarge window 0 until it covers window 1, reprogram window 1 (for example as a configuration window) while it is hidden, and then shrink window 0 again to reveal it. Windows 0 and 1 have a programmable power-of-two size. Window 2 is a fixed 16 MB window that always produces I/O cycles. The prefetch flag of windows 0 and 1 is stored but does not affect translation.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset every window is disabled, so every lookup misses until software enables a window.
- R2: Register writes use `regSel` codes 0 = window 0 base, 1 = window 0 map, 2 = window 1 base, 3 = window 1 map, 4 = window 2 base, 5 = window 2 map. Writes with codes 6 and 7 are ignored. A write takes effect for a lookup presented in the next cycle.
- R3: Base register of windows 0 and 1: bits 31:20 give the base address bits 31:20, bits 7:4 a size code, bit 3 a stored prefetch flag, bit 0 the enable. The window covers 1 MB shifted left by the size code; codes above 11 act as 11 (2 GB). The window claims an address when it is enabled and the address bits 31:20 above the window size equal the base bits.
- R4: Map register of windows 0 and 1 (bits 15:0 of the write data): bits 15:4 give downstream address bits 31:20, bits 3:1 the cycle type, bit 0 the address-low enable. The translated address takes the map bits above the window size and the incoming address bits below it.
- R5: On a hit in window 0 or 1, `rspType` and `rspAdLow` are the map's cycle type (000 interrupt acknowledge, 001 I/O, 011 memory, 101 configuration, 110 memory multiple) and address-low enable.
- R6: Window 2 base register: bits 15:8 give address bits 31:24, bit 0 the enable; its map register bits 15:8 give downstream bits 31:24. A hit yields `{map[15:8], addr[23:0]}`, cycle type 001 and address-low enable 0.
- R7: When several enabled windows claim an address, the lowest-numbered one wins and `rspWin` reports its index (0, 1 or 2).
- R8: A disabled window never claims an address, whatever its base and size.
- R9: On a miss `rspHit` is 0 and `rspAddr`, `rspType`, `rspAdLow` and `rspWin` are all zero.
- R10: `rspValid` is high exactly in the cycle after `reqValid` was high; the response outputs update only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register select code |
| regWrData | input | 32 | Register write data |
| reqValid | input | 1 | Lookup request valid |
| reqAddr | input | 32 | Local bus address to translate |
| rspValid | output | 1 | Response valid, one cycle after request |
| rspHit | output | 1 | Some window claimed the address |
| rspWin | output | 2 | Index of the winning window |
| rspAddr | output | 32 | Translated downstream address |
| rspType | output | 3 | Downstream cycle type |
| rspAdLow | output | 1 | Address-low enable of the winning window |

## Verification
The hardest situation to reach from the ports is a genuine overlap where a larger lower-numbered window hides a higher one and the hidden window is then reprogrammed and revealed again; random programming rarely lines up two enabled windows on the same addresses. The bench drives that sequence directly (window 0 enlarged to cover window 1, window 1 remapped to configuration cycles, window 0 shrunk) and checks the winner at each step, and also steers random addresses into the programmed windows so hits, overlaps and boundary sizes, including size codes above 11, occur often.

// File: rtl/axl_pkg.sv
package axl_pkg;
  localparam int ADDR_W    = 32;
  localparam int GEN_WIN   = 2;
  localparam int HI_W      = 12;
  localparam int IO_W      = 8;
  localparam int SIZE_W    = 4;
  localparam int MAX_SIZE  = 11;
  localparam int SEL_W     = 3;
  localparam int TYPE_W    = 3;
  localparam int WIN_IDX_W = 2;
  localparam logic [TYPE_W-1:0] CYC_IO = 3'b001;

  typedef struct packed {
    logic [GEN_WIN-1:0] wrBase;
    logic [GEN_WIN-1:0] wrMap;
    logic               wrIoBase;
    logic               wrIoMap;
    logic               capture;
  } ctlStrobes_t;
endpackage

// File: rtl/axl_control.sv
module axl_control
  import axl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [SEL_W-1:0] regSel,
  input  logic             reqValid,
  output ctlStrobes_t      strobes
);
  always_comb begin
    strobes = '0;
    strobes.capture = reqValid;
    if (regWrEn) begin
      case (regSel)
        3'd0: strobes.wrBase[0] = 1'b1;
        3'd1: strobes.wrMap[0]  = 1'b1;
        3'd2: strobes.wrBase[1] = 1'b1;
        3'd3: strobes.wrMap[1]  = 1'b1;
        3'd4: strobes.wrIoBase  = 1'b1;
        3'd5: strobes.wrIoMap   = 1'b1;
        default: ;
      endcase
    end
  end

  // R2: at most one register written per cycle, none for codes 6 and 7
  p_one_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrBase, strobes.wrMap, strobes.wrIoBase, strobes.wrIoMap}));
  p_bad_sel_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel > 3'd5) |->
      !(|{strobes.wrBase, strobes.wrMap, strobes.wrIoBase, strobes.wrIoMap}));
endmodule

// File: rtl/axl_datapath.sv
module axl_datapath
  import axl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strobes,
  input  logic [ADDR_W-1:0]    regWrData,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 rspValid,
  output logic                 rspHit,
  output logic [WIN_IDX_W-1:0] rspWin,
  output logic [ADDR_W-1:0]    rspAddr,
  output logic [TYPE_W-1:0]    rspType,
  output logic                 rspAdLow
);
  localparam int LOW_W = ADDR_W - HI_W;
  localparam int IO_LOW_W = ADDR_W - IO_W;

  logic [HI_W-1:0]   genBase  [GEN_WIN];
  logic [SIZE_W-1:0] genSize  [GEN_WIN];
  logic              genPref  [GEN_WIN];
  logic              genEn    [GEN_WIN];
  logic [HI_W-1:0]   genMap   [GEN_WIN];
  logic [TYPE_W-1:0] genType  [GEN_WIN];
  logic              genAdLow [GEN_WIN];
  logic [IO_W-1:0]   ioBase;
  logic              ioEn;
  logic [IO_W-1:0]   ioMap;

  logic [GEN_WIN-1:0] genHit;
  logic [ADDR_W-1:0]  genXlate [GEN_WIN];

  for (genvar w = 0; w < GEN_WIN; w++) begin : g_win
    logic [SIZE_W-1:0] sizeClamp;
    logic [HI_W-1:0]   hiMask;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        genBase[w] <= '0; genSize[w] <= '0; genPref[w] <= 1'b0; genEn[w] <= 1'b0;
        genMap[w]  <= '0; genType[w] <= '0; genAdLow[w] <= 1'b0;
      end else begin
        if (strobes.wrBase[w]) begin
          genBase[w] <= regWrData[ADDR_W-1:LOW_W];
          genSize[w] <= regWrData[7:4];
          genPref[w] <= regWrData[3];
          genEn[w]   <= regWrData[0];
        end
        if (strobes.wrMap[w]) begin
          genMap[w]   <= regWrData[15:4];
          genType[w]  <= regWrData[3:1];
          genAdLow[w] <= regWrData[0];
        end
      end
    end

    always_comb begin
      sizeClamp = (genSize[w] > SIZE_W'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE) : genSize[w];
      hiMask    = {HI_W{1'b1}} << sizeClamp;
      genHit[w] = genEn[w] &&
                  (((reqAddr[ADDR_W-1:LOW_W] ^ genBase[w]) & hiMask) == '0);
      genXlate[w] = {(genMap[w] & hiMask) | (reqAddr[ADDR_W-1:LOW_W] & ~hiMask),
                     reqAddr[LOW_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioBase <= '0; ioEn <= 1'b0; ioMap <= '0;
    end else begin
      if (strobes.wrIoBase) begin
        ioBase <= regWrData[15:8];
        ioEn   <= regWrData[0];
      end
      if (strobes.wrIoMap) ioMap <= regWrData[15:8];
    end
  end

  logic ioHit;
  assign ioHit = ioEn && (reqAddr[ADDR_W-1:IO_LOW_W] == ioBase);

  logic                 nxtHit;
  logic [WIN_IDX_W-1:0] nxtWin;
  logic [ADDR_W-1:0]    nxtAddr;
  logic [TYPE_W-1:0]    nxtType;
  logic                 nxtAdLow;

  always_comb begin
    nxtHit = 1'b0; nxtWin = '0; nxtAddr = '0; nxtType = '0; nxtAdLow = 1'b0;
    if (ioHit) begin
      nxtHit  = 1'b1;
      nxtWin  = WIN_IDX_W'(GEN_WIN);
      nxtAddr = {ioMap, reqAddr[IO_LOW_W-1:0]};
      nxtType = CYC_IO;
    end
    for (int w = GEN_WIN - 1; w >= 0; w--) begin
      if (genHit[w]) begin
        nxtHit   = 1'b1;
        nxtWin   = WIN_IDX_W'(w);
        nxtAddr  = genXlate[w];
        nxtType  = genType[w];
        nxtAdLow = genAdLow[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0; rspHit <= 1'b0; rspWin <= '0;
      rspAddr <= '0; rspType <= '0; rspAdLow <= 1'b0;
    end else begin
      rspValid <= strobes.capture;
      if (strobes.capture) begin
        rspHit <= nxtHit; rspWin <= nxtWin; rspAddr <= nxtAddr;
        rspType <= nxtType; rspAdLow <= nxtAdLow;
      end
    end
  end

  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspAddr == '0 && rspType == '0 && !rspAdLow && rspWin == '0));
  p_io_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit && rspWin == WIN_IDX_W'(GEN_WIN)) |-> (rspType == CYC_IO && !rspAdLow));
  p_win_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (rspWin <= WIN_IDX_W'(GEN_WIN)));
  p_valid_next_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> rspValid);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> (!rspValid && $stable(rspAddr) && $stable(rspHit)));
  p_low_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && genHit[0]) |=> (rspAddr[LOW_W-1:0] == $past(reqAddr[LOW_W-1:0])));
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
  import axl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [SEL_W-1:0]     regSel,
  input  logic [ADDR_W-1:0]    regWrData,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 rspValid,
  output logic                 rspHit,
  output logic [WIN_IDX_W-1:0] rspWin,
  output logic [ADDR_W-1:0]    rspAddr,
  output logic [TYPE_W-1:0]    rspType,
  output logic                 rspAdLow
);
  ctlStrobes_t strobes;

  axl_control u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .reqValid(reqValid), .strobes(strobes)
  );

  axl_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWrData(regWrData),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspHit(rspHit), .rspWin(rspWin),
    .rspAddr(rspAddr), .rspType(rspType), .rspAdLow(rspAdLow)
  );
endmodule

// File: tb/addr_window_xlate_test.sv
`timescale 1ns/1ps
module addr_window_xlate_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regSel = '0;
  logic [31:0] regWrData = '0;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic rspValid, rspHit, rspAdLow;
  logic [1:0] rspWin;
  logic [31:0] rspAddr;
  logic [2:0] rspType;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [6];

  always #2 clk = ~clk;

  addr_window_xlate uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .reqValid(reqValid), .reqAddr(reqAddr), .rspValid(rspValid), .rspHit(rspHit),
    .rspWin(rspWin), .rspAddr(rspAddr), .rspType(rspType), .rspAdLow(rspAdLow)
  );

  // expected {hit, win[1:0], addr[31:0], type[2:0], adLow}
  function automatic logic [38:0] expect_of(input logic [31:0] a);
    for (int w = 0; w < 2; w++) begin
      logic [31:0] b, m;
      int sz;
      logic [11:0] mask;
      b = mdl[2*w]; m = mdl[2*w+1];
      sz = (b[7:4] > 4'd11) ? 11 : int'(b[7:4]);
      mask = 12'hFFF << sz;
      if (b[0] && ((a[31:20] & mask) == (b[31:20] & mask)))
        return {1'b1, 2'(w), (m[15:4] & mask) | (a[31:20] & ~mask), a[19:0], m[3:1], m[0]};
    end
    if (mdl[4][0] && a[31:24] == mdl[4][15:8])
      return {1'b1, 2'd2, mdl[5][15:8], a[23:0], 3'b001, 1'b0};
    return '0;
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (sel < 3'd6) mdl[sel] = d;
  endtask

  task automatic look(input logic [31:0] a, input string tag);
    logic [38:0] exp, got;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    exp = expect_of(a);
    @(negedge clk);
    reqValid = 1'b0;
    got = {rspHit, rspWin, rspAddr, rspType, rspAdLow};
    checks++;
    if (!rspValid || got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h valid=%b got=%h exp=%h", tag, a, rspValid, got, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 6; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state: everything misses, R10 no valid without request
    checks++;
    if (rspValid !== 1'b0) begin errors++; $display("FAIL R10 rspValid=%b exp=0", rspValid); end
    look(32'h4000_0000, "R1");
    look(32'h0000_0000, "R1 R9");

    // R3 R4 R5 window 0: 256MB at 0x4000_0000, memory to 0x8000_0000
    wr(3'd0, 32'h4000_0081);
    wr(3'd1, 32'h0000_8007);
    look(32'h4123_4567, "R3 R4 R5");
    look(32'h4FFF_FFFF, "R3 top edge");
    look(32'h5000_0000, "R3 R9 past edge");
    // R6 window 2 I/O
    wr(3'd4, 32'h0000_6001);
    wr(3'd5, 32'h0000_AB00);
    look(32'h60AB_CDEF, "R6");
    // R7 overlap: enlarge window 0 to 512MB hiding window 1
    wr(3'd2, 32'h5000_0081);
    wr(3'd3, 32'h0000_900B);
    look(32'h5800_0000, "R7 window1 visible");
    wr(3'd0, 32'h4000_0091);
    look(32'h5800_0000, "R7 window0 hides window1");
    wr(3'd3, 32'h0000_000B);   // hidden remap to configuration
    wr(3'd2, 32'h5000_0041);
    look(32'h5012_3456, "R7 still hidden");
    wr(3'd0, 32'h4000_0081);
    look(32'h5012_3456, "R7 R5 revealed config");
    // R3 size code above 11 acts as 2GB
    wr(3'd0, 32'h8000_00F1);
    look(32'hFFFF_0000, "R3 clamp");
    look(32'h6001_0000, "R3 R7 clamp below");
    // R8 disabled window
    wr(3'd0, 32'h4000_0080);
    look(32'h4000_1000, "R8");
    // R2 codes 6 and 7 ignored
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0000_FFFF);
    look(32'h4000_1000, "R2 ignored");
    look(32'h60AB_CDEF, "R2 ignored io");

    // random programming and lookups
    void'($urandom(32'd1234));
    for (int it = 0; it < 400; it++) begin
      logic [31:0] a;
      int pick;
      if (it % 25 == 0) begin
        for (int s = 0; s < 6; s++) begin
          logic [31:0] d;
          d = $urandom;
          if (s == 0 || s == 2 || s == 4) d[0] = ($urandom % 4) != 0;
          wr(3'(s), d);
        end
      end
      pick = $urandom % 4;
      a = $urandom;
      if (pick < 2) a[31:20] = mdl[2*pick][31:20] ^ (12'($urandom) & ~(12'hFFF << 3));
      else if (pick == 2) a[31:24] = mdl[4][15:8];
      look(a, "R3 R4 R5 R6 R7 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule